// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Control

This block holds the byte-wide control register of a real-time clock and the periodic interrupt generator that the register drives. A one-cycle tick arriving 256 times per second advances a free-running 9-bit sub-second counter. A 3-bit rate code picks the interrupt period on a non-uniform ladder that runs from 1/256 s to 2 s, or turns periodic events off. Each time the selected period elapses, a sticky flag is set. The interrupt request is raised while that flag is set and the rate code is nonzero.

Software reaches the register through a plain bus with write enable, write data and read data. The flag can be set or cleared from software. The count-enable and run bits are stored in the register and driven out. The adjust bit and the divider-reset bit act as one-cycle strobes for logic outside this block.

There are two resets. An asynchronous active-low power-on reset is released synchronously and loads the full initial value. A synchronous active-low manual reset clears every field except the count-enable and run bits.

Top module: `rtc_pirq_ctrl`

## Requirements
- R1: While power-on reset is asserted, and after it is released, the register reads 8'h09 (only bit 3 and bit 0 set) and the sub-second counter is zero.
- R2: The register bit positions are: bit 7 flag, bits 6:4 rate code, bit 3 count-enable, bit 2 adjust, bit 1 divider reset, bit 0 run. A write with wr_en high loads all eight bits at the clock edge, and rd_data shows the stored value.
- R3: A manual reset (mrst_n low at a clock edge) clears bits 7:4, 2 and 1, leaves bits 3 and 0 unchanged, and overrides any write made in the same cycle.
- R4: Rate code 000 never sets the flag, and irq stays 0 under code 000 even when software has set the flag.
- R5: With the counter cleared and a tick on every cycle, the flag is first set after P ticks, where P is 1, 4, 16, 64, 128, 256 or 512 for rate codes 001 to 111 in turn. An event fires when the incremented counter has its low log2(P) bits at zero.
- R6: The flag is set by a period event or by writing 1 to bit 7. It is cleared only by writing 0 to bit 7 (or by a reset), and otherwise it holds.
- R7: If a period event and a write of 0 to bit 7 fall in the same cycle, the flag ends up set.
- R8: irq equals the flag ANDed with a nonzero rate code.
- R9: The counter advances only on a cycle where the tick is present and bit 0 (run) is 1.
- R10: Writing 1 to bit 1 makes div_rst_strobe and read-back bit 1 high for exactly one cycle. During that cycle the counter is forced to zero and ignores ticks.
- R11: Writing 1 to bit 2 makes adj_strobe and read-back bit 2 high for exactly one cycle, after which both read 0.
- R12: clk_en_o follows bit 3 and run_o follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| tick_256 | input | 1 | One-cycle pulse at 256 Hz |
| wr_en | input | 1 | Register write enable |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Periodic interrupt request |
| clk_en_o | output | 1 | Stored count-enable bit |
| run_o | output | 1 | Stored run bit |
| adj_strobe | output | 1 | One-cycle adjust request |
| div_rst_strobe | output | 1 | One-cycle divider reset request |

## Verification
The hardest case to reach from the ports is a period event landing in the same cycle as a software write that clears the flag, because the event cycle depends on the hidden counter phase. The stimulus first clears the counter through the divider-reset strobe and runs the 1/256 s code, so that every tick is an event. It then issues the clearing write together with a tick. The long periods need up to 512 ticks after a known counter clear, so the directed sequences drive a tick every cycle and count cycles to the first flag. Random traffic with a bench reference model mixes writes, manual resets and ticks on top of these sequences.

// File: rtl/rtc_pirq_pkg.sv
package rtc_pirq_pkg;

  localparam int unsigned CNT_W   = 9;
  localparam int unsigned RATE_W  = 3;
  localparam logic [7:0]  POR_VAL = 8'h09;

  typedef logic [RATE_W-1:0] rate_t;

  // Field order is the software-visible bit order (7 down to 0).
  typedef struct packed {
    logic  flag;
    rate_t rate;
    logic  clk_en;
    logic  adj;
    logic  div_rst;
    logic  run;
  } ctrl_t;

  // Number of low counter bits that must roll over for each rate code.
  function automatic int unsigned rate_shift(input int unsigned code);
    case (code)
      1:       return 0;
      2:       return 2;
      3:       return 4;
      4:       return 6;
      5:       return 7;
      6:       return 8;
      7:       return 9;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_pirq_rst_sync.sv
module rtc_pirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/rtc_pirq_divider.sv
module rtc_pirq_divider #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clear,
  output logic             adv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_inc_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             adv;

  always_comb begin
    adv    = tick & run & ~clear;
    cnt_en = adv | clear;
    cnt_d  = clear ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign adv_o     = adv;
  assign cnt_o     = cnt_q;
  assign cnt_inc_o = cnt_q + 1'b1;

endmodule

// File: rtl/rtc_pirq_rate_sel.sv
module rtc_pirq_rate_sel
  import rtc_pirq_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt_inc,
  input  rate_t            rate,
  output logic             period_ev
);

  localparam int unsigned NCODE = 1 << RATE_W;

  logic [NCODE-1:0] hit;

  assign hit[0] = 1'b0;

  for (genvar c = 1; c < NCODE; c++) begin : g_rate
    localparam int unsigned SH = rate_shift(c);
    if (SH == 0) begin : g_every
      assign hit[c] = 1'b1;
    end else begin : g_roll
      assign hit[c] = (cnt_inc[SH-1:0] == '0);
    end
  end

  assign period_ev = adv & hit[rate];

endmodule

// File: rtl/rtc_pirq_regs.sv
module rtc_pirq_regs
  import rtc_pirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mrst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       period_ev,
  output ctrl_t      ctrl_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d         = ctrl_q;
    ctrl_d.adj     = 1'b0;
    ctrl_d.div_rst = 1'b0;
    if (!mrst_n) begin
      ctrl_d.flag = 1'b0;
      ctrl_d.rate = '0;
    end else begin
      if (wr_en) begin
        ctrl_d = ctrl_t'(wr_data);
      end
      if (period_ev) begin
        ctrl_d.flag = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(POR_VAL);
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/rtc_pirq_ctrl.sv
module rtc_pirq_ctrl
  import rtc_pirq_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       mrst_n,
  input  logic       tick_256,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       clk_en_o,
  output logic       run_o,
  output logic       adj_strobe,
  output logic       div_rst_strobe
);

  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic             adv;
  logic             period_ev;
  logic [CNT_W-1:0] sub_cnt;
  logic [CNT_W-1:0] sub_cnt_inc;

  rtc_pirq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (rst_sync_n)
  );

  rtc_pirq_divider #(.CNT_W(CNT_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick_256),
    .run       (ctrl.run),
    .clear     (ctrl.div_rst),
    .adv_o     (adv),
    .cnt_o     (sub_cnt),
    .cnt_inc_o (sub_cnt_inc)
  );

  rtc_pirq_rate_sel #(.CNT_W(CNT_W)) u_sel (
    .adv       (adv),
    .cnt_inc   (sub_cnt_inc),
    .rate      (ctrl.rate),
    .period_ev (period_ev)
  );

  rtc_pirq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mrst_n    (mrst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .period_ev (period_ev),
    .ctrl_o    (ctrl)
  );

  assign rd_data        = ctrl;
  assign irq            = ctrl.flag & (|ctrl.rate);
  assign clk_en_o       = ctrl.clk_en;
  assign run_o          = ctrl.run;
  assign adj_strobe     = ctrl.adj;
  assign div_rst_strobe = ctrl.div_rst;

endmodule

// File: rtl/rtc_pirq_chk.sv
module rtc_pirq_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic             irq,
  input logic             adj_strobe,
  input logic             div_rst_strobe,
  input logic             period_ev,
  input logic [CNT_W-1:0] cnt
);

  // R6: a set flag survives unless cleared by a write or a manual reset
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] && mrst_n && !(wr_en && !wr_data[7]) |=> rd_data[7]);

  // R7: a period event always leaves the flag set
  a_r7_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    period_ev && mrst_n |=> rd_data[7]);

  // R3: manual reset keeps bits 3 and 0 and clears the rest
  a_r3_mrst_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !mrst_n |=> (rd_data[3] == $past(rd_data[3])) && (rd_data[0] == $past(rd_data[0]))
                && (rd_data[7:4] == 4'd0) && (rd_data[2:1] == 2'd0));

  // R10: the counter is zero after a divider reset strobe
  a_r10_counter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst_strobe |=> (cnt == '0));

  // R11: adjust strobe lasts one cycle unless rewritten
  a_r11_adj_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    adj_strobe && !(wr_en && wr_data[2] && mrst_n) |=> !adj_strobe);

  // R9: counter holds while run is 0
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] && !div_rst_strobe |=> $stable(cnt));

  // R4: no events under rate code 000
  a_r4_no_event_code0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6:4] == 3'd0) |-> !period_ev);

  // R8: interrupt only with a nonzero rate code and a set flag
  a_r8_irq_rate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[6:4] != 3'd0) && rd_data[7]);

endmodule

bind rtc_pirq_ctrl rtc_pirq_chk #(.CNT_W(rtc_pirq_pkg::CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .mrst_n         (mrst_n),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .irq            (irq),
  .adj_strobe     (adj_strobe),
  .div_rst_strobe (div_rst_strobe),
  .period_ev      (period_ev),
  .cnt            (sub_cnt)
);

// File: tb/tb_rtc_pirq_ctrl.sv
module tb_rtc_pirq_ctrl;

  logic       clk;
  logic       por_n;
  logic       mrst_n;
  logic       tick_256;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq;
  logic       clk_en_o;
  logic       run_o;
  logic       adj_strobe;
  logic       div_rst_strobe;

  int unsigned n_chk;
  int unsigned n_fail;
  logic        done;

  logic [7:0] m_q;
  logic [8:0] m_cnt;

  rtc_pirq_ctrl dut (
    .clk            (clk),
    .por_n          (por_n),
    .mrst_n         (mrst_n),
    .tick_256       (tick_256),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .irq            (irq),
    .clk_en_o       (clk_en_o),
    .run_o          (run_o),
    .adj_strobe     (adj_strobe),
    .div_rst_strobe (div_rst_strobe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R5 ladder: ticks per event for each rate code
  function automatic int unsigned period_of(input logic [2:0] code);
    case (code)
      3'd1: return 1;
      3'd2: return 4;
      3'd3: return 16;
      3'd4: return 64;
      3'd5: return 128;
      3'd6: return 256;
      3'd7: return 512;
      default: return 0;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic w, input logic [7:0] d, input logic tk, input logic mr);
    logic       adv;
    logic [8:0] inc;
    logic       ev;
    logic [7:0] nq;
    int unsigned p;
    adv = tk && m_q[0] && !m_q[1];
    inc = m_cnt + 9'd1;
    p   = period_of(m_q[6:4]);
    ev  = adv && (p != 0) && ((inc & 9'(p - 1)) == 9'd0);
    nq  = m_q;
    nq[2] = 1'b0;
    nq[1] = 1'b0;
    if (!mr) begin
      nq[7:4] = 4'd0;
    end else begin
      if (w) nq = d;
      if (ev) nq[7] = 1'b1;
    end
    if (m_q[1]) m_cnt = 9'd0;
    else if (adv) m_cnt = inc;
    m_q = nq;
  endtask

  task automatic compare_all();
    check(rd_data == m_q, "R2 read data", rd_data, m_q);
    check(irq == (m_q[7] && (m_q[6:4] != 3'd0)), "R8 irq", irq, m_q[7] && (m_q[6:4] != 3'd0));
    check(adj_strobe == m_q[2], "R11 adjust strobe", adj_strobe, m_q[2]);
    check(div_rst_strobe == m_q[1], "R10 divider strobe", div_rst_strobe, m_q[1]);
    check((run_o == m_q[0]) && (clk_en_o == m_q[3]), "R12 run/count-enable",
          {run_o, clk_en_o}, {m_q[0], m_q[3]});
  endtask

  // Called at a falling edge: drives one cycle and checks after the next falling edge.
  task automatic cyc(input logic w, input logic [7:0] d, input logic tk, input logic mr);
    wr_en    = w;
    wr_data  = d;
    tick_256 = tk;
    mrst_n   = mr;
    if (por_n) model_step(w, d, tk, mr);
    @(negedge clk);
    wr_en    = 1'b0;
    tick_256 = 1'b0;
    mrst_n   = 1'b1;
    compare_all();
  endtask

  task automatic idle(input int unsigned n);
    for (int unsigned i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic power_on();
    por_n = 1'b0;
    #1;
    m_q   = 8'h09;
    m_cnt = 9'd0;
    check(rd_data == 8'h09, "R1 value during reset", rd_data, 8'h09);
    @(negedge clk);
    @(negedge clk);
    por_n = 1'b1;
    idle(4);
    check(rd_data == 8'h09, "R1 value after release", rd_data, 8'h09);
  endtask

  initial begin
    done = 1'b0;
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    por_n    = 1'b0;
    mrst_n   = 1'b1;
    tick_256 = 1'b0;
    wr_en    = 1'b0;
    wr_data  = 8'h00;
    m_q      = 8'h09;
    m_cnt    = 9'd0;
    void'($urandom(32'h5EED_0123));
    @(negedge clk);
    power_on();
    check(irq == 1'b0, "R8 irq after reset", irq, 0);
    check(clk_en_o && run_o, "R12 outputs after reset", {clk_en_o, run_o}, 2'b11);

    // R5: measure each period from a cleared counter
    for (int c = 1; c < 8; c++) begin
      int unsigned n;
      cyc(1'b1, {1'b0, 3'(c), 4'b1011}, 1'b0, 1'b1);
      idle(1);
      n = 0;
      do begin
        cyc(1'b0, 8'h00, 1'b1, 1'b1);
        n++;
      end while (!rd_data[7] && n < 600);
      check(n == period_of(3'(c)), "R5 period ticks", n, period_of(3'(c)));
      check(irq == 1'b1, "R8 irq on event", irq, 1);
    end

    // R6: flag sticky with ticks, then cleared by a write of 0
    cyc(1'b1, 8'b1_011_1001, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) cyc(1'b0, 8'h00, 1'b1, 1'b1);
    check(rd_data[7] == 1'b1, "R6 flag holds", rd_data[7], 1);
    cyc(1'b1, 8'b0_011_1001, 1'b0, 1'b1);
    check(rd_data[7] == 1'b0, "R6 flag cleared by write", rd_data[7], 0);

    // R7: event and write of 0 in the same cycle
    cyc(1'b1, 8'b0_001_1011, 1'b0, 1'b1);
    idle(1);
    cyc(1'b1, 8'b0_001_1001, 1'b1, 1'b1);
    check(rd_data[7] == 1'b1, "R7 event beats clearing write", rd_data[7], 1);

    // R4: code 000 with the flag set gives no irq; with the flag clear no events
    cyc(1'b1, 8'b1_000_1001, 1'b0, 1'b1);
    check(irq == 1'b0, "R4 no irq under code 0", irq, 0);
    check(rd_data == 8'h89, "R4 flag set by write", rd_data, 8'h89);
    cyc(1'b1, 8'b0_000_1001, 1'b0, 1'b1);
    for (int i = 0; i < 600; i++) cyc(1'b0, 8'h00, 1'b1, 1'b1);
    check(rd_data[7] == 1'b0, "R4 no event under code 0", rd_data[7], 0);

    // R9: run bit 0 freezes the counter
    cyc(1'b1, 8'b0_001_1000, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b0, 8'h00, 1'b1, 1'b1);
    check(rd_data[7] == 1'b0, "R9 no advance while stopped", rd_data[7], 0);
    cyc(1'b1, 8'b0_001_1001, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b1, 1'b1);
    check(rd_data[7] == 1'b1, "R9 advance once running", rd_data[7], 1);

    // R10 and R11: one-cycle strobes
    cyc(1'b1, 8'b0_010_1111, 1'b0, 1'b1);
    check(adj_strobe && div_rst_strobe && (rd_data[2:1] == 2'b11), "R11 R10 strobes high",
          {adj_strobe, div_rst_strobe, rd_data[2:1]}, 4'b1111);
    idle(1);
    check(!adj_strobe && !div_rst_strobe && (rd_data[2:1] == 2'b00), "R11 R10 strobes drop",
          {adj_strobe, div_rst_strobe, rd_data[2:1]}, 4'b0000);

    // R3: manual reset
    cyc(1'b1, 8'hF8, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    check(rd_data == 8'h08, "R3 manual reset keeps bit 3", rd_data, 8'h08);
    cyc(1'b1, 8'hE1, 1'b0, 1'b1);
    cyc(1'b1, 8'hFF, 1'b0, 1'b0);
    check(rd_data == 8'h01, "R3 manual reset overrides write", rd_data, 8'h01);

    // Random traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      logic       w;
      logic       mr;
      logic       tk;
      logic [7:0] d;
      w  = ($urandom % 8) == 0;
      mr = ($urandom % 64) != 0;
      tk = ($urandom % 2) == 0;
      d  = 8'($urandom);
      if (($urandom % 4) != 0) d[0] = 1'b1;
      if (($urandom % 4) != 0) d[1] = 1'b0;
      cyc(w, d, tk, mr);
    end

    // R1: power-on reset mid-run
    cyc(1'b1, 8'hF6, 1'b1, 1'b1);
    power_on();
    check(m_cnt == 9'd0 && rd_data == 8'h09, "R1 reset mid-run", rd_data, 8'h09);
    cyc(1'b1, 8'b0_010_1001, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b0, 8'h00, 1'b1, 1'b1);
    check(rd_data[7] == 1'b1, "R1 counter zero after reset", rd_data[7], 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule